// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the host write path of a page-programmed non-volatile memory and watches every host write cycle (an address and a data byte). It recognises short unlock sequences of three, six or seven writes. Each sequence leads to its own mode change: enabling or disabling software write protection, starting a chip erase, entering or leaving identification mode, or locking one of two 16 KB boot regions at the bottom and the top of the address space. Command steps compare only the low 15 address bits. A write that breaks a sequence sends the decoder back to idle, and that same write is then judged again as though it had arrived in idle.

The decoder also decides which ordinary writes may go into the page buffer. While protection is on, a page load opens only after the protected-write prefix. While protection is off, any plain write opens one. Inside an open load window every write is page data. A byte is taken only if it lies in the page latched by the first byte and outside a locked boot region. The window closes a fixed number of cycles after the last accepted byte (or after it opened). When it closes and at least one byte was taken, a one-cycle commit pulse tells the array to start its internal write.

Two resets are used. The cold reset models first power-up: protection on, no locks. The warm reset models a power transition: it returns the sequence logic to idle and leaves identification mode, but keeps the protection and lock state.

States: `ST_IDLE` (no sequence in progress), `ST_KEY1` (first unlock byte seen), `ST_KEY2` (two unlock bytes seen), `ST_EXT3` (extended prefix marker seen), `ST_EXT4` and `ST_EXT5` (second unlock pair in progress), `ST_BOOT7` (waiting for the lock target write), `ST_LOAD` (page load window open).

Transitions:
- `ST_IDLE`→`ST_KEY1` on AA@5555.
- `ST_IDLE`→`ST_LOAD` on an accepted plain write while unprotected.
- `ST_KEY1`→`ST_KEY2` on 55@2AAA.
- `ST_KEY2`→`ST_LOAD` on A0@5555, which also turns protection on.
- `ST_KEY2`→`ST_IDLE` on 90@5555 (identification on) or F0@5555 (identification off).
- `ST_KEY2`→`ST_EXT3` on 80@5555.
- `ST_EXT3`→`ST_EXT4` on AA@5555.
- `ST_EXT4`→`ST_EXT5` on 55@2AAA.
- `ST_EXT5`→`ST_IDLE` on 20 (protection off), 10 (erase) or 60 (identification on), each to 5555.
- `ST_EXT5`→`ST_BOOT7` on 40@5555.
- `ST_BOOT7`→`ST_IDLE` on the lock write.
- `ST_LOAD`→`ST_IDLE` on window expiry.
- In any state from `ST_KEY1` to `ST_BOOT7`, a mismatching write falls back to the `ST_IDLE` evaluation.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After cold reset `prot_en`=1, `lock_low`=0, `lock_high`=0, `id_mode`=0 and `load_open`=0.
- R2: Warm reset (`rst_n` low) returns to `ST_IDLE` and clears `id_mode`, while `prot_en`, `lock_low` and `lock_high` keep their values.
- R3: While `prot_en`=1, a write outside an open window that is not part of a command gives no `load_ok` and opens no window.
- R4: The writes AA@5555, 55@2AAA, A0@5555 set `prot_en` and raise `load_open` in the cycle after the third write; each accepted page byte then pulses `load_ok` in the cycle after its write.
- R5: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 clear `prot_en`. Afterwards a plain write is accepted (`load_ok`=1) and opens a window.
- R6: The six writes ending 10@5555 (same first five as R5) pulse `erase_start` for exactly one cycle, the cycle after the sixth write, when no lock is set.
- R7: AA@5555, 55@2AAA, 90@5555, or the six writes ending 60@5555, set `id_mode`; AA@5555, 55@2AAA, F0@5555 clear it.
- R8: The six writes ending 40@5555, followed by data 00 to full address 0, set `lock_low`. Followed instead by data FF to the all-ones address, they set `lock_high`. Any other seventh write sets neither. Locks clear only on cold reset.
- R9: With either lock set, the erase sequence gives no `erase_start`. A page write whose address bits above bit 13 are all zero (with `lock_low`) or all one (with `lock_high`) is not accepted.
- R10: Command steps compare address bits [14:0] only; the upper address bits do not affect matching.
- R11: A write that does not match the expected step aborts the sequence. That write is judged again as an idle write: AA@5555 starts a new sequence, and when unprotected any other write becomes plain page data.
- R12: Inside a window, a byte whose address bits above the byte-in-page field differ from the first accepted byte's page is not accepted.
- R13: `commit` pulses for one cycle exactly `LOAD_TIMEOUT` cycles after the last `load_ok` cycle, and `load_open` falls with it. A window that accepted no byte closes after the same time without `commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low power-up reset; restores protection on and clears the locks |
| rst_n | input | 1 | Active-low warm reset for a power transition; keeps protection and locks |
| wr_en | input | 1 | One-cycle strobe marking a host write cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| prot_en | output | 1 | Software write protection active |
| id_mode | output | 1 | Identification mode active |
| lock_low | output | 1 | Bottom 16 KB region locked |
| lock_high | output | 1 | Top 16 KB region locked |
| erase_start | output | 1 | One-cycle pulse: chip erase accepted |
| load_open | output | 1 | Page load window open |
| load_ok | output | 1 | One-cycle pulse: the previous write went into the page buffer |
| commit | output | 1 | One-cycle pulse: window closed with data, start the internal write |

## Verification
The sequences are driven whole, and also with their upper address bits disturbed, which separates a 15-bit compare from a full-width one. Broken sequences are driven in two forms: one where the aborting write is itself AA@5555, and one where it is garbage. These show whether the decoder restarts correctly or wrongly resumes. Plain writes are tried in protected and unprotected mode, inside and outside the latched page, and into locked and unlocked regions; this tells the write gate apart from the command path. The window end is timed in cycles from the last accepted byte, and a window with no data is checked for the absence of `commit`.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int          CMD_AW  = 15;
    localparam logic [14:0] ADR_ONE = 15'h5555;
    localparam logic [14:0] ADR_TWO = 15'h2AAA;

    localparam logic [7:0] CD_UNLK1 = 8'hAA;
    localparam logic [7:0] CD_UNLK2 = 8'h55;
    localparam logic [7:0] CD_PWR   = 8'hA0;
    localparam logic [7:0] CD_EXT   = 8'h80;
    localparam logic [7:0] CD_IDQ   = 8'h90;
    localparam logic [7:0] CD_IDX   = 8'hF0;
    localparam logic [7:0] CD_UNPR  = 8'h20;
    localparam logic [7:0] CD_ERASE = 8'h10;
    localparam logic [7:0] CD_IDL   = 8'h60;
    localparam logic [7:0] CD_BOOT  = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_EXT3,
        ST_EXT4,
        ST_EXT5,
        ST_BOOT7,
        ST_LOAD
    } seq_state_t;

    typedef struct packed {
        logic at_one;
        logic at_two;
        logic d_unlk1;
        logic d_unlk2;
        logic d_pwr;
        logic d_ext;
        logic d_idq;
        logic d_idx;
        logic d_unpr;
        logic d_erase;
        logic d_idl;
        logic d_boot;
        logic key_low;
        logic key_high;
        logic in_low;
        logic in_high;
    } cyc_hit_t;

    typedef struct packed {
        logic prot_on;
        logic prot_off;
        logic id_on;
        logic id_off;
        logic erase;
        logic lock_low;
        logic lock_high;
        logic open;
    } seq_ev_t;

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int BOOT_W = 14
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output cyc_hit_t          hit
);

    localparam int RG_W = ADDR_W - BOOT_W;

    logic [CMD_AW-1:0] cmd_addr;
    logic [RG_W-1:0]   region;

    assign cmd_addr = wr_addr[CMD_AW-1:0];
    assign region   = wr_addr[ADDR_W-1:BOOT_W];

    always_comb begin
        hit          = '0;
        hit.at_one   = (cmd_addr == ADR_ONE);
        hit.at_two   = (cmd_addr == ADR_TWO);
        hit.d_unlk1  = (wr_data == CD_UNLK1);
        hit.d_unlk2  = (wr_data == CD_UNLK2);
        hit.d_pwr    = (wr_data == CD_PWR);
        hit.d_ext    = (wr_data == CD_EXT);
        hit.d_idq    = (wr_data == CD_IDQ);
        hit.d_idx    = (wr_data == CD_IDX);
        hit.d_unpr   = (wr_data == CD_UNPR);
        hit.d_erase  = (wr_data == CD_ERASE);
        hit.d_idl    = (wr_data == CD_IDL);
        hit.d_boot   = (wr_data == CD_BOOT);
        hit.key_low  = (wr_addr == '0) && (wr_data == 8'h00);
        hit.key_high = (&wr_addr) && (wr_data == 8'hFF);
        hit.in_low   = (region == '0);
        hit.in_high  = (&region);
    end

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
(
    input  logic       clk,
    input  logic       cold_rst_n,
    input  logic       rst_n,
    input  logic       wr_en,
    input  cyc_hit_t   hit,
    input  logic       prot_en,
    input  logic       data_accept,
    input  logic       expire,
    output logic       data_try,
    output logic       in_load,
    output seq_ev_t    ev
);

    seq_state_t state_q, state_n;
    logic       use_idle;
    logic       start_hit;

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n)  state_q <= ST_IDLE;
        else if (!rst_n)  state_q <= ST_IDLE;
        else              state_q <= state_n;
    end

    assign start_hit = hit.at_one & hit.d_unlk1;
    assign in_load   = (state_q == ST_LOAD);

    // Does the current write fail to match the step this state expects?
    always_comb begin
        unique case (state_q)
            ST_IDLE:  use_idle = 1'b1;
            ST_KEY1:  use_idle = !(hit.at_two & hit.d_unlk2);
            ST_KEY2:  use_idle = !(hit.at_one & (hit.d_pwr | hit.d_idq |
                                                 hit.d_idx | hit.d_ext));
            ST_EXT3:  use_idle = !(hit.at_one & hit.d_unlk1);
            ST_EXT4:  use_idle = !(hit.at_two & hit.d_unlk2);
            ST_EXT5:  use_idle = !(hit.at_one & (hit.d_unpr | hit.d_erase |
                                                 hit.d_idl | hit.d_boot));
            ST_BOOT7: use_idle = !(hit.key_low | hit.key_high);
            ST_LOAD:  use_idle = 1'b0;
            default:  use_idle = 1'b1;
        endcase
    end

    assign data_try = wr_en & (in_load | (use_idle & !start_hit & !prot_en));

    // Next state and mode events
    always_comb begin
        state_n = state_q;
        ev      = '0;
        if (state_q == ST_LOAD) begin
            if (expire) state_n = ST_IDLE;
        end else if (wr_en) begin
            if (use_idle) begin
                if (start_hit)        state_n = ST_KEY1;
                else if (data_accept) state_n = ST_LOAD;
                else                  state_n = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_KEY1: state_n = ST_KEY2;
                    ST_KEY2: begin
                        if (hit.d_pwr) begin
                            state_n    = ST_LOAD;
                            ev.prot_on = 1'b1;
                            ev.open    = 1'b1;
                        end else if (hit.d_ext) begin
                            state_n = ST_EXT3;
                        end else begin
                            state_n   = ST_IDLE;
                            ev.id_on  = hit.d_idq;
                            ev.id_off = hit.d_idx;
                        end
                    end
                    ST_EXT3: state_n = ST_EXT4;
                    ST_EXT4: state_n = ST_EXT5;
                    ST_EXT5: begin
                        if (hit.d_boot) begin
                            state_n = ST_BOOT7;
                        end else begin
                            state_n     = ST_IDLE;
                            ev.prot_off = hit.d_unpr;
                            ev.erase    = hit.d_erase;
                            ev.id_on    = hit.d_idl;
                        end
                    end
                    ST_BOOT7: begin
                        state_n      = ST_IDLE;
                        ev.lock_low  = hit.key_low;
                        ev.lock_high = hit.key_high;
                    end
                    default: state_n = ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmdseq_window.sv
module cmdseq_window #(
    parameter int ADDR_W       = 19,
    parameter int PAGE_W       = 8,
    parameter int LOAD_TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_n,
    input  logic              in_load,
    input  logic              open_ev,
    input  logic              data_try,
    input  logic              blocked,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              accept,
    output logic              expire,
    output logic              load_ok,
    output logic              commit
);

    localparam int PG_W = ADDR_W - PAGE_W;
    localparam int TW   = $clog2(LOAD_TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(LOAD_TIMEOUT - 1);

    logic [PG_W-1:0] page_q;
    logic [PG_W-1:0] page_in;
    logic            have_q;
    logic [TW-1:0]   tmr_q;

    assign page_in = wr_addr[ADDR_W-1:PAGE_W];
    assign accept  = data_try & !blocked &
                     (!in_load | !have_q | (page_in == page_q));
    assign expire  = in_load & !accept & (tmr_q == T_LAST);

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            page_q  <= '0;
            have_q  <= 1'b0;
            tmr_q   <= '0;
            load_ok <= 1'b0;
            commit  <= 1'b0;
        end else if (!rst_n) begin
            page_q  <= '0;
            have_q  <= 1'b0;
            tmr_q   <= '0;
            load_ok <= 1'b0;
            commit  <= 1'b0;
        end else begin
            load_ok <= accept;
            commit  <= expire & have_q;
            if (open_ev | accept)         tmr_q <= '0;
            else if (in_load)             tmr_q <= tmr_q + 1'b1;
            if (open_ev | expire) begin
                have_q <= 1'b0;
            end else if (accept) begin
                have_q <= 1'b1;
                page_q <= page_in;
            end
        end
    end

endmodule

// File: rtl/cmdseq_modes.sv
module cmdseq_modes
    import cmdseq_pkg::*;
(
    input  logic    clk,
    input  logic    cold_rst_n,
    input  logic    rst_n,
    input  seq_ev_t ev,
    output logic    prot_en,
    output logic    id_mode,
    output logic    lock_low,
    output logic    lock_high,
    output logic    erase_start
);

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            prot_en     <= 1'b1;
            id_mode     <= 1'b0;
            lock_low    <= 1'b0;
            lock_high   <= 1'b0;
            erase_start <= 1'b0;
        end else if (!rst_n) begin
            id_mode     <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            if (ev.prot_on)        prot_en <= 1'b1;
            else if (ev.prot_off)  prot_en <= 1'b0;
            if (ev.id_on)          id_mode <= 1'b1;
            else if (ev.id_off)    id_mode <= 1'b0;
            if (ev.lock_low)       lock_low  <= 1'b1;
            if (ev.lock_high)      lock_high <= 1'b1;
            erase_start <= ev.erase & !(lock_low | lock_high);
        end
    end

endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int PAGE_W       = 8,
    parameter int BOOT_W       = 14,
    parameter int LOAD_TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              prot_en,
    output logic              id_mode,
    output logic              lock_low,
    output logic              lock_high,
    output logic              erase_start,
    output logic              load_open,
    output logic              load_ok,
    output logic              commit
);

    cyc_hit_t hit;
    seq_ev_t  ev;
    logic     data_try;
    logic     data_accept;
    logic     expire;
    logic     in_load;
    logic     blocked;

    assign blocked   = (hit.in_low & lock_low) | (hit.in_high & lock_high);
    assign load_open = in_load;

    cmdseq_match #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_match (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit)
    );

    cmdseq_fsm u_fsm (
        .clk         (clk),
        .cold_rst_n  (cold_rst_n),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .hit         (hit),
        .prot_en     (prot_en),
        .data_accept (data_accept),
        .expire      (expire),
        .data_try    (data_try),
        .in_load     (in_load),
        .ev          (ev)
    );

    cmdseq_window #(
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W),
        .LOAD_TIMEOUT (LOAD_TIMEOUT)
    ) u_window (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .rst_n      (rst_n),
        .in_load    (in_load),
        .open_ev    (ev.open),
        .data_try   (data_try),
        .blocked    (blocked),
        .wr_addr    (wr_addr),
        .accept     (data_accept),
        .expire     (expire),
        .load_ok    (load_ok),
        .commit     (commit)
    );

    cmdseq_modes u_modes (
        .clk         (clk),
        .cold_rst_n  (cold_rst_n),
        .rst_n       (rst_n),
        .ev          (ev),
        .prot_en     (prot_en),
        .id_mode     (id_mode),
        .lock_low    (lock_low),
        .lock_high   (lock_high),
        .erase_start (erase_start)
    );

endmodule

// File: rtl/cmd_seq_decoder_chk.sv
module cmd_seq_decoder_chk #(
    parameter int ADDR_W       = 19,
    parameter int LOAD_TIMEOUT = 16
) (
    input logic              clk,
    input logic              cold_rst_n,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              prot_en,
    input logic              id_mode,
    input logic              lock_low,
    input logic              lock_high,
    input logic              erase_start,
    input logic              load_open,
    input logic              load_ok,
    input logic              commit
);

    int quiet_cnt;

    // cycles since the last load_ok (or since the window opened)
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n)     quiet_cnt <= 0;
        else if (!rst_n)     quiet_cnt <= 0;
        else if (!load_open) quiet_cnt <= 0;
        else if (load_ok)    quiet_cnt <= 1;
        else                 quiet_cnt <= quiet_cnt + 1;
    end

    assert_loadok_in_window_R4: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !rst_n) load_ok |-> load_open);

    assert_prot_fall_on_write_R5: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !rst_n) $fell(prot_en) |-> $past(wr_en));

    assert_erase_single_R6: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !rst_n) erase_start |=> !erase_start);

    assert_lock_sticky_R8: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !rst_n) (lock_low || lock_high) |=>
            ($past(lock_low) -> lock_low) && ($past(lock_high) -> lock_high));

    assert_erase_refused_R9: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !rst_n) (lock_low || lock_high) |-> !erase_start);

    assert_commit_closes_R13: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !rst_n) commit |-> !load_open && $past(load_open));

    assert_commit_timing_R13: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !rst_n) commit |-> quiet_cnt == LOAD_TIMEOUT);

endmodule

bind cmd_seq_decoder cmd_seq_decoder_chk #(
    .ADDR_W       (ADDR_W),
    .LOAD_TIMEOUT (LOAD_TIMEOUT)
) u_chk (.*);

// File: tb/cmd_seq_decoder_tb.sv
module cmd_seq_decoder_tb;

    localparam int AW = 19;
    localparam int T  = 16;

    logic          clk = 1'b0;
    logic          cold_rst_n = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic prot_en, id_mode, lock_low, lock_high, erase_start;
    logic load_open, load_ok, commit;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cmd_seq_decoder #(.ADDR_W(AW), .LOAD_TIMEOUT(T)) u_dut (
        .clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_en(prot_en), .id_mode(id_mode), .lock_low(lock_low),
        .lock_high(lock_high), .erase_start(erase_start),
        .load_open(load_open), .load_ok(load_ok), .commit(commit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one write; returns in the cycle after the capturing edge
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic seq3(input logic [7:0] d);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, d);
    endtask

    task automatic seq6(input logic [7:0] d);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, d);
    endtask

    task automatic wait_close(input string tag);
        for (int i = 0; i < 3 * T && load_open; i++) @(negedge clk);
        chk(tag, load_open, 0);
    endtask

    task automatic t_reset;
        chk("R1 prot_en", prot_en, 1);
        chk("R1 lock_low", lock_low, 0);
        chk("R1 lock_high", lock_high, 0);
        chk("R1 id_mode", id_mode, 0);
        chk("R1 load_open", load_open, 0);
    endtask

    task automatic t_protected_plain;
        wr(19'h01234, 8'h5A);
        chk("R3 load_ok", load_ok, 0);
        chk("R3 load_open", load_open, 0);
    endtask

    task automatic t_prefix_load;
        int n;
        seq3(8'hA0);
        chk("R4 prot_en", prot_en, 1);
        chk("R4 load_open", load_open, 1);
        wr(19'h01205, 8'h11);
        chk("R4 load_ok", load_ok, 1);
        wr(19'h01306, 8'h22);
        chk("R12 other page", load_ok, 0);
        chk("R12 window stays", load_open, 1);
        wr(19'h012FF, 8'h33);
        chk("R4 second byte", load_ok, 1);
        n = 0;
        for (int i = 0; i < 3 * T && !commit; i++) begin
            @(negedge clk);
            n++;
        end
        chk("R13 commit delay", n, T);
        @(negedge clk);
        chk("R13 commit one cycle", commit, 0);
        chk("R13 window closed", load_open, 0);
    endtask

    task automatic t_prefix_empty;
        int seen;
        seen = 0;
        seq3(8'hA0);
        for (int i = 0; i < T + 4; i++) begin
            @(negedge clk);
            if (commit) seen++;
        end
        chk("R13 empty no commit", seen, 0);
        chk("R13 empty closed", load_open, 0);
    endtask

    task automatic t_ident;
        wr(19'h45555, 8'hAA); wr(19'h72AAA, 8'h55); wr(19'h35555, 8'h90);
        chk("R10 upper bits ignored", id_mode, 1);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
        seq3(8'hF0);
        chk("R11 restart on AA", id_mode, 0);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
        wr(19'h01111, 8'h11); wr(19'h05555, 8'h90);
        chk("R11 abort not resumed", id_mode, 0);
        seq6(8'h60);
        chk("R7 six-byte entry", id_mode, 1);
    endtask

    task automatic warm_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_warm_unprotect;
        warm_reset();
        chk("R2 id cleared", id_mode, 0);
        chk("R2 prot kept on", prot_en, 1);
        seq6(8'h20);
        chk("R5 prot off", prot_en, 0);
        wr(19'h02100, 8'h77);
        chk("R5 plain accepted", load_ok, 1);
        chk("R5 window open", load_open, 1);
        wait_close("R5 close");
        warm_reset();
        chk("R2 prot kept off", prot_en, 0);
    endtask

    task automatic t_erase;
        seq6(8'h10);
        chk("R6 erase pulse", erase_start, 1);
        @(negedge clk);
        chk("R6 erase one cycle", erase_start, 0);
    endtask

    task automatic t_locks;
        seq6(8'h40);
        wr(19'h00100, 8'h12);
        chk("R8 bad key no lock", lock_low | lock_high, 0);
        chk("R11 abort write as data", load_ok, 1);
        wait_close("R11 close");
        seq6(8'h40);
        wr(19'h00000, 8'h00);
        chk("R8 lock_low", lock_low, 1);
        chk("R8 lock_high untouched", lock_high, 0);
        seq6(8'h10);
        chk("R9 erase refused", erase_start, 0);
        wr(19'h00010, 8'h01);
        chk("R9 low region blocked", load_ok, 0);
        wr(19'h40000, 8'h02);
        chk("R9 unlocked region ok", load_ok, 1);
        wait_close("R9 close");
        seq6(8'h40);
        wr(19'h7FFFF, 8'hFF);
        chk("R8 lock_high", lock_high, 1);
        wr(19'h7FF00, 8'h03);
        chk("R9 high region blocked", load_ok, 0);
        warm_reset();
        chk("R2 locks kept", {30'd0, lock_low, lock_high}, 3);
        @(negedge clk); cold_rst_n = 1'b0;
        @(negedge clk); cold_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cold clears locks", lock_low | lock_high, 0);
        chk("R1 cold prot on", prot_en, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protected_plain();
        t_prefix_load();
        t_prefix_empty();
        t_ident();
        t_warm_unprotect();
        t_erase();
        t_locks();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule